// File: doc/BRIEF.md
# Keyed Flash Command Dispatcher

This block sits at the front of a flash memory controller and turns peripheral-bus register writes into launches towards a flash engine. A 16-bit control write carries an unlock byte in its upper half and a 7-bit operation code in its low bits. The write is accepted only if all of the following hold: the unlock byte is correct, the dispatcher is idle, and the code is both defined and allowed in the current security state. An accepted write latches the code together with the target address. The dispatcher then waits until the memory read path is quiet before it raises a single-cycle launch request. A rejected write changes nothing except a sticky programming-error flag, which software clears through a separate status write.

The dispatcher holds two one-way protection bits. The security bit is set when a set-security operation completes. The chip-erase hard lock is set when a hard-lock operation completes, and that operation is only allowed once the security bit is set. Neither bit can be cleared by any command. Flash array timing, page-buffer storage and region-lock storage are not part of this block. They sit behind the request/done handshake.

The controller is one state machine with three states:
- `ST_IDLE`: ready for a new command.
- `ST_PEND`: a command has been accepted but not yet launched.
- `ST_BUSY`: the engine is working on the command.

It has three transitions:
- *accept* (`ST_IDLE`→`ST_PEND`, on a valid control write).
- *launch* (`ST_PEND`→`ST_BUSY`, in the first pending cycle with the memory bus idle).
- *finish* (`ST_BUSY`→`ST_IDLE`, on engine done).

Top module: `nvm_cmd_dispatch`

## Requirements
- R1: A control write (`reg_wr_en`=1, `reg_wr_sel`=0) is accepted only when `reg_wdata[15:8]` equals 0xA5 in that same write. An accepted code `reg_wdata[6:0]` and address `addr_in` are later presented unchanged on `eng_cmd` and `eng_addr` with exactly one `eng_req` per accepted write.
- R2: A control write with any other upper byte launches nothing, leaves `ctrl_rdata` unchanged and sets `prog_err`.
- R3: A control write made while a command is pending or busy is discarded (no launch, `ctrl_rdata` code field unchanged) and sets `prog_err`.
- R4: `ready` is 1 only in `ST_IDLE`. It falls the cycle after an accepted write and rises the cycle after `eng_done`. In that same cycle `done_pulse` is 1 for exactly one cycle.
- R5: `eng_req` is asserted for a single cycle, in the first pending cycle in which `mem_bus_busy` is 0. A command accepted while `mem_bus_busy` is 1 stays pending until the bus is idle.
- R6: `ctrl_rdata` is {7'b0, pending, 1'b0, last accepted code}. Bit 8 is 1 only in `ST_PEND`. The reset value is 0x0000.
- R7: Defined codes are 0x02, 0x04, 0x05, 0x06, 0x1A, 0x1C, 0x40–0x46 and 0x7F. Every other code is rejected with `prog_err` set and no launch.
- R8: Codes 0x05 and 0x06 are accepted only while `secure` is 0 and `addr_in` lies in [USER_ROW_BASE, USER_ROW_BASE+USER_ROW_SPAN), which is by default 0x8000–0x803F. Otherwise they are rejected with `prog_err` set.
- R9: Code 0x45 sets `secure` when its `eng_done` arrives. Code 0x7F is accepted only while `secure` is 1, and sets `chip_erase_locked` on completion. Both bits stay set until reset.
- R10: A status write (`reg_wr_en`=1, `reg_wr_sel`=1) with `reg_wdata[0]`=1 clears `prog_err`. With bit 0 at 0, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Peripheral register write strobe |
| reg_wr_sel | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | 16 | Write data |
| addr_in | input | ADDR_W | Target address from the address register |
| mem_bus_busy | input | 1 | Memory-path bus access in progress |
| eng_done | input | 1 | Engine completion pulse |
| ctrl_rdata | output | 16 | Control register readback |
| ready | output | 1 | Dispatcher idle and able to accept a command |
| done_pulse | output | 1 | One-cycle completion indication |
| prog_err | output | 1 | Sticky programming-error flag |
| secure | output | 1 | Security bit |
| chip_erase_locked | output | 1 | Permanent chip-erase hard lock |
| eng_req | output | 1 | Single-cycle launch request |
| eng_cmd | output | 7 | Code of the launched command |
| eng_addr | output | ADDR_W | Address of the launched command |

## Verification
The assertions take four things for granted about the inputs:
- The engine pulses `eng_done` only while a launched command is in `ST_BUSY`.
- `reg_wr_sel` distinguishes the control write from the status write, so the two never arrive in the same cycle.
- `mem_bus_busy` drops within bounded time.
- Addresses reach `addr_in` in the cycle of the control write.

The bench's engine model stays within these limits. It starts its done countdown only when it sees `eng_req` and returns a single `eng_done` a fixed number of cycles later. The bench drives one register write per cycle and holds the memory bus busy for only a few cycles at a time.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

    localparam logic [7:0] CMD_KEY = 8'hA5;

    typedef enum logic [6:0] {
        OP_ROW_ERASE   = 7'h02,
        OP_PAGE_WRITE  = 7'h04,
        OP_AUX_ERASE   = 7'h05,
        OP_AUX_WRITE   = 7'h06,
        OP_DF_ERASE    = 7'h1A,
        OP_DF_WRITE    = 7'h1C,
        OP_REG_LOCK    = 7'h40,
        OP_REG_UNLOCK  = 7'h41,
        OP_PWR_LOW_SET = 7'h42,
        OP_PWR_LOW_CLR = 7'h43,
        OP_PBUF_CLEAR  = 7'h44,
        OP_SET_SECURE  = 7'h45,
        OP_CACHE_INV   = 7'h46,
        OP_SET_CE_LOCK = 7'h7F
    } nvm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_BUSY = 2'd2
    } disp_state_e;

    function automatic logic op_defined(input logic [6:0] code);
        logic hit;
        unique case (code)
            OP_ROW_ERASE, OP_PAGE_WRITE, OP_AUX_ERASE, OP_AUX_WRITE,
            OP_DF_ERASE, OP_DF_WRITE, OP_REG_LOCK, OP_REG_UNLOCK,
            OP_PWR_LOW_SET, OP_PWR_LOW_CLR, OP_PBUF_CLEAR,
            OP_SET_SECURE, OP_CACHE_INV, OP_SET_CE_LOCK: hit = 1'b1;
            default:                                     hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/nvm_op_checker.sv
module nvm_op_checker
    import nvm_cmd_pkg::*;
#(
    parameter int          ADDR_W        = 16,
    parameter logic [15:0] USER_ROW_BASE = 16'h8000,
    parameter int          USER_ROW_SPAN = 64
) (
    input  logic [6:0]        code_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              secure_i,
    output logic              allowed_o
);
    localparam logic [ADDR_W:0] ROW_LO = (ADDR_W+1)'(USER_ROW_BASE);
    localparam logic [ADDR_W:0] ROW_HI = ROW_LO + (ADDR_W+1)'(USER_ROW_SPAN);

    logic in_user_row;

    always_comb begin
        in_user_row = ({1'b0, addr_i} >= ROW_LO) && ({1'b0, addr_i} < ROW_HI);
    end

    always_comb begin
        unique case (code_i)
            OP_AUX_ERASE,
            OP_AUX_WRITE:   allowed_o = !secure_i && in_user_row;
            OP_SET_CE_LOCK: allowed_o = secure_i;
            default:        allowed_o = op_defined(code_i);
        endcase
    end

endmodule

// File: rtl/nvm_protect_bits.sv
module nvm_protect_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic set_secure_i,
    input  logic set_lock_i,
    output logic secure_o,
    output logic lock_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            secure_o <= 1'b0;
            lock_o   <= 1'b0;
        end else begin
            if (set_secure_i) secure_o <= 1'b1;
            if (set_lock_i)   lock_o   <= 1'b1;
        end
    end

    // R9
    lock_needs_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> secure_o);

    // R9
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);

    // R9
    secure_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        secure_o |=> secure_o);

endmodule

// File: rtl/nvm_err_flag.sv
module nvm_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic err_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     err_o <= 1'b0;
        else if (set_i) err_o <= 1'b1;
        else if (clr_i) err_o <= 1'b0;
    end

    // R2
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> err_o);

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(err_o));

endmodule

// File: rtl/nvm_cmd_dispatch.sv
module nvm_cmd_dispatch
    import nvm_cmd_pkg::*;
#(
    parameter int          ADDR_W        = 16,
    parameter logic [15:0] USER_ROW_BASE = 16'h8000,
    parameter int          USER_ROW_SPAN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_sel,
    input  logic [15:0]       reg_wdata,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mem_bus_busy,
    input  logic              eng_done,
    output logic [15:0]       ctrl_rdata,
    output logic              ready,
    output logic              done_pulse,
    output logic              prog_err,
    output logic              secure,
    output logic              chip_erase_locked,
    output logic              eng_req,
    output logic [6:0]        eng_cmd,
    output logic [ADDR_W-1:0] eng_addr
);
    disp_state_e       state_q, state_d;
    logic [6:0]        code_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;

    logic ctrl_wr, stat_wr, key_match, op_allowed, accept, err_set, err_clr;
    logic finish, set_secure, set_lock;

    assign ctrl_wr   = reg_wr_en && !reg_wr_sel;
    assign stat_wr   = reg_wr_en &&  reg_wr_sel;
    assign key_match = (reg_wdata[15:8] == CMD_KEY);

    nvm_op_checker #(
        .ADDR_W       (ADDR_W),
        .USER_ROW_BASE(USER_ROW_BASE),
        .USER_ROW_SPAN(USER_ROW_SPAN)
    ) op_check_i (
        .code_i   (reg_wdata[6:0]),
        .addr_i   (addr_in),
        .secure_i (secure),
        .allowed_o(op_allowed)
    );

    assign accept  = ctrl_wr && (state_q == ST_IDLE) && key_match && op_allowed;
    assign err_set = ctrl_wr && !accept;
    assign err_clr = stat_wr && reg_wdata[0];
    assign finish  = (state_q == ST_BUSY) && eng_done;

    assign set_secure = finish && (code_q == OP_SET_SECURE);
    assign set_lock   = finish && (code_q == OP_SET_CE_LOCK);

    nvm_err_flag err_i (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(err_set),
        .clr_i(err_clr),
        .err_o(prog_err)
    );

    nvm_protect_bits prot_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_secure_i(set_secure),
        .set_lock_i  (set_lock),
        .secure_o    (secure),
        .lock_o      (chip_erase_locked)
    );

    // next-state logic: accept, launch, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)        state_d = ST_PEND;
            ST_PEND: if (!mem_bus_busy) state_d = ST_BUSY;
            ST_BUSY: if (eng_done)      state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // state register and command latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            addr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
            if (accept) begin
                code_q <= reg_wdata[6:0];
                addr_q <= addr_in;
            end
        end
    end

    // outputs
    always_comb begin
        ready      = (state_q == ST_IDLE);
        eng_req    = (state_q == ST_PEND) && !mem_bus_busy;
        eng_cmd    = code_q;
        eng_addr   = addr_q;
        done_pulse = done_q;
        ctrl_rdata = {7'b0, (state_q == ST_PEND), 1'b0, code_q};
    end

    // R5
    launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> (!eng_req && !ready));

    // R4
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> ready);

    // R4
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |-> (state_q == ST_BUSY));

    // R3
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ready) |=> prog_err);

endmodule

// File: tb/nvm_cmd_dispatch_tb_top.sv
module nvm_cmd_dispatch_tb_top;
    localparam int ENG_LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] addr_in = '0;
    logic        mem_bus_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic [15:0] ctrl_rdata;
    logic        ready, done_pulse, prog_err, secure, chip_erase_locked, eng_req;
    logic [6:0]  eng_cmd;
    logic [15:0] eng_addr;

    typedef struct packed {
        logic [6:0]  cmd;
        logic [15:0] addr;
    } launch_t;

    launch_t exp_q[$];
    int n_chk  = 0;
    int n_fail = 0;
    int done_cnt = 0;

    always #2 clk = ~clk;

    nvm_cmd_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wdata(reg_wdata), .addr_in(addr_in), .mem_bus_busy(mem_bus_busy),
        .eng_done(eng_done), .ctrl_rdata(ctrl_rdata), .ready(ready),
        .done_pulse(done_pulse), .prog_err(prog_err), .secure(secure),
        .chip_erase_locked(chip_erase_locked), .eng_req(eng_req),
        .eng_cmd(eng_cmd), .eng_addr(eng_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor + engine model: pops expected launches, answers with done
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            eng_done = 1'b0;
            if (done_cnt > 0) begin
                done_cnt--;
                if (done_cnt == 0) eng_done = 1'b1;
            end
            if (eng_req === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk("R1 unexpected launch", {25'd0, eng_cmd}, 32'hFFFF_FFFF);
                end else begin
                    launch_t e;
                    e = exp_q.pop_front();
                    chk("R1 launch code", {25'd0, eng_cmd}, {25'd0, e.cmd});
                    chk("R1 launch addr", {16'd0, eng_addr}, {16'd0, e.addr});
                end
                done_cnt = ENG_LAT;
            end
        end
    end

    task automatic ctrl_wr(input logic [7:0] key, input logic [6:0] cmd, input logic [15:0] addr);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 1'b0;
        reg_wdata = {key, 1'b0, cmd}; addr_in = addr;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0; addr_in = 16'hFFFF;
        #1;
    endtask

    task automatic stat_wr(input logic bit0);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = 1'b1; reg_wdata = {15'd0, bit0};
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_sel = 1'b0; reg_wdata = '0;
        #1;
    endtask

    task automatic wait_idle();
        while (ready !== 1'b1) begin
            @(negedge clk); #1;
        end
        chk("R4 done pulse high", {31'd0, done_pulse}, 32'd1);
        @(negedge clk); #1;
        chk("R4 done pulse single", {31'd0, done_pulse}, 32'd0);
    endtask

    task automatic launch_ok(input logic [6:0] cmd, input logic [15:0] addr, input string req);
        exp_q.push_back('{cmd: cmd, addr: addr});
        ctrl_wr(8'hA5, cmd, addr);
        chk(req, {31'd0, prog_err}, 32'd0);
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R4 watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R6 reset readback", {16'd0, ctrl_rdata}, 32'h0);
        chk("R4 reset ready", {31'd0, ready}, 32'd1);
        chk("R10 reset err", {31'd0, prog_err}, 32'd0);
        chk("R9 reset protect", {30'd0, secure, chip_erase_locked}, 32'd0);

        // R2 wrong key
        ctrl_wr(8'h5A, 7'h02, 16'h0010);
        chk("R2 err set", {31'd0, prog_err}, 32'd1);
        chk("R2 readback", {16'd0, ctrl_rdata}, 32'h0);
        chk("R2 still ready", {31'd0, ready}, 32'd1);

        // R10 clear semantics
        stat_wr(1'b0);
        chk("R10 bit0 zero no effect", {31'd0, prog_err}, 32'd1);
        stat_wr(1'b1);
        chk("R10 clear", {31'd0, prog_err}, 32'd0);

        // R1 / R5 / R6 plain launch, then R3 write while busy
        exp_q.push_back('{cmd: 7'h02, addr: 16'h0010});
        ctrl_wr(8'hA5, 7'h02, 16'h0010);
        chk("R6 pending readback", {16'd0, ctrl_rdata}, 32'h0102);
        chk("R4 ready low", {31'd0, ready}, 32'd0);
        chk("R5 immediate launch", {31'd0, eng_req}, 32'd1);
        chk("R1 no err", {31'd0, prog_err}, 32'd0);
        ctrl_wr(8'hA5, 7'h04, 16'h0020);
        chk("R3 busy write err", {31'd0, prog_err}, 32'd1);
        chk("R3 busy readback", {16'd0, ctrl_rdata}, 32'h0002);
        wait_idle();
        stat_wr(1'b1);

        // R5 memory bus contention
        exp_q.push_back('{cmd: 7'h04, addr: 16'h0040});
        mem_bus_busy = 1'b1;
        ctrl_wr(8'hA5, 7'h04, 16'h0040);
        chk("R5 held by bus", {31'd0, eng_req}, 32'd0);
        chk("R6 pending bit", {16'd0, ctrl_rdata}, 32'h0104);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); #1;
            chk("R5 still held", {31'd0, eng_req}, 32'd0);
        end
        @(negedge clk);
        mem_bus_busy = 1'b0;
        #1;
        chk("R5 launch after idle", {31'd0, eng_req}, 32'd1);
        wait_idle();

        // R3 write while pending
        exp_q.push_back('{cmd: 7'h1A, addr: 16'h0100});
        mem_bus_busy = 1'b1;
        ctrl_wr(8'hA5, 7'h1A, 16'h0100);
        ctrl_wr(8'hA5, 7'h1C, 16'h0100);
        chk("R3 pending write err", {31'd0, prog_err}, 32'd1);
        chk("R3 pending readback", {16'd0, ctrl_rdata}, 32'h011A);
        @(negedge clk);
        mem_bus_busy = 1'b0;
        wait_idle();
        stat_wr(1'b1);

        // R7 reserved codes
        foreach (exp_q[i]) begin end
        begin
            logic [6:0] rsv [7] = '{7'h00, 7'h03, 7'h07, 7'h1B, 7'h3F, 7'h47, 7'h7E};
            for (int i = 0; i < 7; i++) begin
                ctrl_wr(8'hA5, rsv[i], 16'h0200);
                chk("R7 reserved err", {31'd0, prog_err}, 32'd1);
                chk("R7 reserved no accept", {31'd0, ready}, 32'd1);
                stat_wr(1'b1);
            end
        end

        // R7 defined codes that need no special state
        begin
            logic [6:0] ok_ops [10] = '{7'h02, 7'h04, 7'h1A, 7'h1C, 7'h40,
                                        7'h41, 7'h42, 7'h43, 7'h44, 7'h46};
            for (int i = 0; i < 10; i++) begin
                launch_ok(ok_ops[i], 16'h0300 + 16'(i), "R7 defined accepted");
            end
        end

        // R8 auxiliary row rules
        launch_ok(7'h05, 16'h8000, "R8 aux erase in row");
        launch_ok(7'h06, 16'h803F, "R8 aux write row end");
        ctrl_wr(8'hA5, 7'h05, 16'h8040);
        chk("R8 above row err", {31'd0, prog_err}, 32'd1);
        stat_wr(1'b1);
        ctrl_wr(8'hA5, 7'h06, 16'h7FFF);
        chk("R8 below row err", {31'd0, prog_err}, 32'd1);
        stat_wr(1'b1);

        // R9 hard lock before security
        ctrl_wr(8'hA5, 7'h7F, 16'h0000);
        chk("R9 lock needs secure", {31'd0, prog_err}, 32'd1);
        chk("R9 lock stays clear", {31'd0, chip_erase_locked}, 32'd0);
        stat_wr(1'b1);

        // R9 security set on completion
        exp_q.push_back('{cmd: 7'h45, addr: 16'h0000});
        ctrl_wr(8'hA5, 7'h45, 16'h0000);
        chk("R9 secure not before done", {31'd0, secure}, 32'd0);
        wait_idle();
        chk("R9 secure set", {31'd0, secure}, 32'd1);

        // R8 aux refused once secure
        ctrl_wr(8'hA5, 7'h05, 16'h8000);
        chk("R8 aux secure err", {31'd0, prog_err}, 32'd1);
        stat_wr(1'b1);

        // R9 hard lock
        launch_ok(7'h7F, 16'h0000, "R9 lock accepted");
        chk("R9 lock set", {31'd0, chip_erase_locked}, 32'd1);
        launch_ok(7'h02, 16'h0400, "R9 later command");
        chk("R9 bits sticky", {30'd0, secure, chip_erase_locked}, 32'd3);

        repeat (3) @(negedge clk);
        #1;
        chk("R1 all launches seen", exp_q.size(), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule